// File: doc/BRIEF.md
# Coprocessor Register Transfer Port

This block sits between a processor core's coprocessor transfer interface and a small register file inside a debug or trace unit. The core announces a transfer with an enable pulse that carries the direction and a 15-bit address made of the instruction's opcode and register fields. Two cycles later it supplies the write data together with a commit strobe that decides whether the transfer really happens.

The block keeps a two-deep queue of announced transfers, so a new transfer may start on every cycle. It decodes the local register number from the instruction fields and ignores transfers whose opcode fields do not address it. Writes take effect only when committed. Read data is registered and appears in the cycle in which the commit decision for that read is due.

Top module: `cpreg_port`

## Requirements
- R1: An access addresses the local register file only when address bits 14:12 and bits 11:8 are all zero. Any other access changes no register, and a read of it returns zero.
- R2: The register number is {addr[2:0], addr[7:4]}, giving 7 bits. Address bit 3 may be 0 or 1, and both values reach the same register.
- R3: A write enabled in cycle E with commit high in cycle E+2 stores the write data present in cycle E+2. The stored value is returned by every later read of that register.
- R4: A write whose commit is low in cycle E+2 changes no register.
- R5: For a read enabled in cycle E, cp_rdata carries the register value during cycle E+2. It is zero in every cycle that is not the data cycle of a read.
- R6: Register numbers at or above NUM_REGS (default 32) read as zero. Writes to them change no implemented register, including the register whose number shares their low bits.
- R7: Enables in consecutive cycles are all served, each with its own data and commit cycle.
- R8: A read enabled one cycle after a write to the same register returns the data of that write when the write is committed.
- R9: While rst is high, the synchronous active-high reset clears all registers and pending transfers, and cp_rdata is zero in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cp_en | input | 1 | Transfer start; cp_wr and cp_addr are valid in this cycle |
| cp_wr | input | 1 | 1 for a write, 0 for a read |
| cp_addr | input | 15 | Opcode and register fields of the transfer instruction |
| cp_commit | input | 1 | Commit decision, due two cycles after cp_en |
| cp_wdata | input | 32 | Write data, due two cycles after cp_en |
| cp_rdata | output | 32 | Registered read data, valid two cycles after cp_en |

## Verification
The hardest case to reach is a read whose register fetch falls in the same cycle as the commit of an earlier write to the same register. In that case the returned value must come from the bypass path and not from the storage. The bench produces it by enabling a write and then, in the next cycle, a read of the same number, and it commits the write with a fresh value. It also overlaps transfers on consecutive cycles. It aims writes at unimplemented numbers that alias implemented ones in their low bits, so that a truncated index would show up as a corrupted neighbour.

// File: rtl/cpreg_pkg.sv
package cpreg_pkg;
  localparam int ADDR_W = 15;
  localparam int NUM_W  = 7;

  typedef struct packed {
    logic             vld;
    logic             wr;
    logic             hit;
    logic [NUM_W-1:0] num;
  } xfer_t;
endpackage

// File: rtl/cpreg_decode.sv
module cpreg_decode
  import cpreg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [NUM_W-1:0]  num
);
  // opcode-1 and primary register field must both be zero
  assign hit = (addr[14:12] == 3'd0) && (addr[11:8] == 4'd0);
  // upper three bits from opcode-2, lower four from the secondary register field
  assign num = {addr[2:0], addr[7:4]};
endmodule

// File: rtl/cpreg_pipe.sv
module cpreg_pipe
  import cpreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wr,
  input  logic             hit,
  input  logic [NUM_W-1:0] num,
  output xfer_t            s1,
  output xfer_t            s2
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1.vld <= en;
      s1.wr  <= wr;
      s1.hit <= hit;
      s1.num <= num;
      s2     <= s1;
    end
  end
endmodule

// File: rtl/cpreg_file.sv
module cpreg_file
  import cpreg_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [NUM_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_req,
  input  logic [NUM_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int             IDX_W = $clog2(NUM_REGS);
  localparam logic [NUM_W:0] LIMIT = (NUM_W+1)'(NUM_REGS);

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic              w_impl;
  logic              r_impl;
  logic              bypass;

  assign w_impl = ({1'b0, waddr} < LIMIT);
  assign r_impl = ({1'b0, raddr} < LIMIT);
  assign bypass = we && w_impl && (waddr == raddr);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (we && w_impl) begin
      mem[waddr[IDX_W-1:0]] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_req && r_impl) begin
      rdata_q <= bypass ? wdata : mem[raddr[IDX_W-1:0]];
    end else begin
      rdata_q <= '0;
    end
  end
endmodule

// File: rtl/cpreg_port.sv
module cpreg_port
  import cpreg_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cp_en,
  input  logic              cp_wr,
  input  logic [14:0]       cp_addr,
  input  logic              cp_commit,
  input  logic [DATA_W-1:0] cp_wdata,
  output logic [DATA_W-1:0] cp_rdata
);
  logic             dec_hit;
  logic [NUM_W-1:0] dec_num;
  xfer_t            s1;
  xfer_t            s2;
  logic             wr_fire;
  logic             rd_req;
  logic [NUM_W-1:0] wr_num;

  cpreg_decode u_dec (
    .addr (cp_addr),
    .hit  (dec_hit),
    .num  (dec_num)
  );

  cpreg_pipe u_pipe (
    .clk (clk),
    .rst (rst),
    .en  (cp_en),
    .wr  (cp_wr),
    .hit (dec_hit),
    .num (dec_num),
    .s1  (s1),
    .s2  (s2)
  );

  assign wr_fire = s2.vld && s2.wr && s2.hit && cp_commit;
  assign rd_req  = s1.vld && !s1.wr && s1.hit;
  assign wr_num  = s2.num;

  cpreg_file #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_file (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_fire),
    .waddr   (wr_num),
    .wdata   (cp_wdata),
    .rd_req  (rd_req),
    .raddr   (s1.num),
    .rdata_q (cp_rdata)
  );
endmodule

// File: rtl/cpreg_port_chk.sv
module cpreg_port_chk #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cp_en,
  input logic              cp_wr,
  input logic [14:0]       cp_addr,
  input logic              cp_commit,
  input logic [DATA_W-1:0] cp_rdata,
  input logic              mem_we,
  input logic [6:0]        mem_waddr
);
  // R5
  rdata_src_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_rdata != '0) |-> ($past(cp_en, 2) && !$past(cp_wr, 2)));

  // R4
  commit_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (cp_commit && $past(cp_en, 2) && $past(cp_wr, 2)));

  // R1
  opcode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(cp_addr[14:8], 2) == 7'd0));

  // R2
  regnum_map_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_waddr == {$past(cp_addr[2:0], 2), $past(cp_addr[7:4], 2)}));

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cp_rdata == '0));
endmodule

bind cpreg_port cpreg_port_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cp_en     (cp_en),
  .cp_wr     (cp_wr),
  .cp_addr   (cp_addr),
  .cp_commit (cp_commit),
  .cp_rdata  (cp_rdata),
  .mem_we    (wr_fire),
  .mem_waddr (wr_num)
);

// File: tb/cpreg_port_bench.sv
module cpreg_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cp_en = 1'b0;
  logic        cp_wr = 1'b0;
  logic [14:0] cp_addr = '0;
  logic        cp_commit = 1'b0;
  logic [31:0] cp_wdata = '0;
  logic [31:0] cp_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [31:0] model [32];

  always #10 clk = ~clk;

  cpreg_port u_cpreg_port (
    .clk       (clk),
    .rst       (rst),
    .cp_en     (cp_en),
    .cp_wr     (cp_wr),
    .cp_addr   (cp_addr),
    .cp_commit (cp_commit),
    .cp_wdata  (cp_wdata),
    .cp_rdata  (cp_rdata)
  );

  function automatic logic [14:0] mk(input logic [2:0] op1, input logic [3:0] crn,
                                     input logic [3:0] crm, input logic cp,
                                     input logic [2:0] op2);
    return {op1, crn, crm, cp, op2};
  endfunction

  function automatic logic [14:0] la(input logic [6:0] n, input logic cp);
    return mk(3'd0, 4'd0, n[3:0], cp, n[6:4]);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", req, got, exp);
    end
  endtask

  // one cycle: drive inputs, return output seen in this cycle
  task automatic cyc(input logic en, input logic wr, input logic [14:0] a,
                     input logic cm, input logic [31:0] wd, output logic [31:0] seen);
    cp_en = en; cp_wr = wr; cp_addr = a; cp_commit = cm; cp_wdata = wd;
    #1 seen = cp_rdata;
    @(negedge clk);
  endtask

  task automatic wr_op(input logic [14:0] a, input logic [31:0] d, input logic cm);
    logic [31:0] s;
    cyc(1, 1, a, 0, '0, s);
    cyc(0, 0, '0, 0, '0, s);
    cyc(0, 0, '0, cm, d, s);
    cyc(0, 0, '0, 0, '0, s);
  endtask

  task automatic rd_op(input logic [14:0] a, output logic [31:0] v);
    logic [31:0] s;
    cyc(1, 0, a, 0, '0, s);
    cyc(0, 0, '0, 0, '0, s);
    cyc(0, 0, '0, 1, '0, v);
    cyc(0, 0, '0, 0, '0, s);
  endtask

  task automatic t_reset();
    check("R9 rdata after reset", cp_rdata, 32'h0);
  endtask

  task automatic t_write_read();
    logic [31:0] s0, s1, s2, s3;
    wr_op(la(7'd3, 1'b0), 32'hA5A5_0003, 1'b1);
    model[3] = 32'hA5A5_0003;
    cyc(1, 0, la(7'd3, 1'b0), 0, '0, s0);
    cyc(0, 0, '0, 0, '0, s1);
    cyc(0, 0, '0, 1, '0, s2);
    cyc(0, 0, '0, 0, '0, s3);
    check("R3 committed write read back", s2, model[3]);
    check("R5 zero before data cycle", s1, 32'h0);
    check("R5 zero after data cycle", s3, 32'h0);
  endtask

  task automatic t_regnum();
    logic [31:0] v;
    wr_op(la(7'h12, 1'b0), 32'h1234_0012, 1'b1);
    model[18] = 32'h1234_0012;
    rd_op(la(7'h12, 1'b1), v);
    check("R2 number from fields, bit3 either value", v, model[18]);
    rd_op(la(7'h02, 1'b0), v);
    check("R2 low field alone selects other reg", v, 32'h0);
  endtask

  task automatic t_cancel();
    logic [31:0] v;
    wr_op(la(7'd3, 1'b1), 32'hDEAD_BEEF, 1'b0);
    rd_op(la(7'd3, 1'b0), v);
    check("R4 uncommitted write ignored", v, model[3]);
  endtask

  task automatic t_nodecode();
    logic [31:0] v;
    wr_op(la(7'd5, 1'b0), 32'h0000_0555, 1'b1);
    model[5] = 32'h0000_0555;
    wr_op(mk(3'd1, 4'd0, 4'd5, 1'b0, 3'd0), 32'hBAD0_0001, 1'b1);
    wr_op(mk(3'd0, 4'd2, 4'd5, 1'b0, 3'd0), 32'hBAD0_0002, 1'b1);
    rd_op(la(7'd5, 1'b0), v);
    check("R1 non-matching opcode write ignored", v, model[5]);
    rd_op(mk(3'd0, 4'd1, 4'd5, 1'b0, 3'd0), v);
    check("R1 non-matching read returns zero", v, 32'h0);
  endtask

  task automatic t_unimpl();
    logic [31:0] v;
    wr_op(la(7'd69, 1'b0), 32'hBAD0_0069, 1'b1);
    rd_op(la(7'd5, 1'b0), v);
    check("R6 unimplemented write leaves alias intact", v, model[5]);
    rd_op(la(7'd69, 1'b0), v);
    check("R6 unimplemented read zero", v, 32'h0);
  endtask

  task automatic t_b2b();
    logic [31:0] s [7];
    cyc(1, 1, la(7'd7, 1'b0), 0, '0, s[0]);
    cyc(1, 1, la(7'd9, 1'b0), 0, '0, s[1]);
    cyc(1, 0, la(7'd7, 1'b0), 1, 32'h7777_0007, s[2]);
    cyc(1, 0, la(7'd9, 1'b0), 1, 32'h9999_0009, s[3]);
    cyc(0, 0, '0, 1, '0, s[4]);
    cyc(0, 0, '0, 1, '0, s[5]);
    cyc(0, 0, '0, 0, '0, s[6]);
    model[7] = 32'h7777_0007;
    model[9] = 32'h9999_0009;
    check("R7 first overlapped read", s[4], model[7]);
    check("R7 second overlapped read", s[5], model[9]);
    check("R5 zero after overlapped reads", s[6], 32'h0);
  endtask

  task automatic t_fwd();
    logic [31:0] s [5];
    cyc(1, 1, la(7'd11, 1'b0), 0, '0, s[0]);
    cyc(1, 0, la(7'd11, 1'b1), 0, '0, s[1]);
    cyc(0, 0, '0, 1, 32'hF0F0_000B, s[2]);
    cyc(0, 0, '0, 1, '0, s[3]);
    cyc(0, 0, '0, 0, '0, s[4]);
    model[11] = 32'hF0F0_000B;
    check("R8 read right after write sees new data", s[3], model[11]);
  endtask

  task automatic t_reset_clear();
    logic [31:0] v;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    #1 check("R9 rdata zero leaving reset", cp_rdata, 32'h0);
    @(negedge clk);
    rd_op(la(7'd3, 1'b0), v);
    check("R9 register cleared by reset", v, 32'h0);
    rd_op(la(7'd18, 1'b0), v);
    check("R9 second register cleared", v, 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    @(negedge clk);
    t_write_read();
    t_regnum();
    t_cancel();
    t_nodecode();
    t_unimpl();
    t_b2b();
    t_fwd();
    t_reset_clear();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule